// File: doc/BRIEF.md
# Periodic Interrupt Timer with Debug Freeze

This block raises a periodic interrupt from a 16-bit down-counter. Software writes a reload value and a control word over a small register bus. Each qualifying tick moves the counter one step toward zero. When the counter reaches zero the block latches a status flag. If the interrupt enable bit is set, the flag drives the interrupt request output. The programmed priority level is driven alongside the request, for the interrupt controller to use.

The time base is a single `tick_en` strobe supplied from outside. A freeze control bit lets a debugger halt the counter while the external `freeze_in` signal is high. A timer enable bit stops the counter and keeps its value. The status flag can only be cleared by writing one to it, and a new zero event in the same cycle keeps the flag set.

Top module: `pit_timer`

## Requirements
- R1: After an active-low reset the control word, the reload value and the counter all read as zero, and `irq` is low.
- R2: Register addresses are as follows. Address 0 is the control word, address 1 is the reload value, address 2 reads the counter (read-only), and address 3 reads zero. Writes to addresses 2 and 3 are ignored. The control word fields are: level in bits [15:8], status in bit 7, interrupt enable in bit 2, freeze control in bit 1 and timer enable in bit 0. Bits [6:3] always read zero. `irq_level` always shows bits [15:8].
- R3: An active tick is a cycle with `tick_en` high, timer enable set, and not frozen. On an active tick the counter drops by one. If the counter is already zero, it loads the reload value instead. A nonzero reload value N therefore gives a period of N+1 ticks.
- R4: The status bit is set on every active tick whose result is a zero count.
- R5: Writing 1 to control bit 7 clears the status bit. Writing 0 to it leaves the status bit unchanged.
- R6: If a clear write and a zero event fall in the same cycle, the status bit stays set.
- R7: `irq` is high exactly while both the interrupt enable bit and the status bit are set.
- R8: While timer enable is 0, the counter keeps its value regardless of `tick_en`.
- R9: With freeze control set and `freeze_in` high, the counter keeps its value. With freeze control clear, `freeze_in` has no effect.
- R10: A reload write while timer enable is 0 also loads the counter in the same cycle. A reload write while timer enable is 1 leaves the counter untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base strobe, one count step per high cycle |
| freeze_in | input | 1 | Debug freeze request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| irq_level | output | 8 | Programmed interrupt priority level |

## Verification
The bench goes after four timing corners.

The first is a reload value of zero, which makes every active tick a zero event. Here a clear write lands on the same edge as a set. A design that let the clear win would drop an interrupt and would show `irq` low for one cycle.

The second is the wrap from zero. A design that reloaded on the same tick that reached zero would run one tick short of the N+1 period.

The third is freeze. The bench raises `freeze_in` with the freeze control bit both set and clear. A design that ignored the control bit would either stall when it should not or count through a debug halt.

The fourth is reload writes under both timer-enable states. A design that loaded the counter on every reload write would lose its phase while running.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W   = 16;
    localparam int CTRL_W  = 16;
    localparam int LVL_W   = 8;
    localparam int ADDR_W  = 2;

    localparam int BIT_PS  = 7;
    localparam int BIT_PIE = 2;
    localparam int BIT_FRZ = 1;
    localparam int BIT_TE  = 0;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             ps;
        logic             pie;
        logic             frz;
        logic             te;
    } ctrl_t;
endpackage

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         zero_evt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] step_d;

    always_comb begin
        st_d     = st_q;
        step_d   = (st_q.cnt == '0) ? reload : st_q.cnt - 1'b1;
        zero_evt = run && (step_d == '0);
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (run) begin
            st_d.cnt = step_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
    import pit_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_reload,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              zero_evt,
    output ctrl_t             ctrl,
    output logic [W-1:0]      reload
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] reload;
    } st_t;

    st_t  st_d, st_q;
    logic clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = wr_ctrl && wdata[BIT_PS];
        if (wr_ctrl) begin
            st_d.ctrl.lvl = wdata[CTRL_W-1 -: LVL_W];
            st_d.ctrl.pie = wdata[BIT_PIE];
            st_d.ctrl.frz = wdata[BIT_FRZ];
            st_d.ctrl.te  = wdata[BIT_TE];
        end
        if (wr_reload) begin
            st_d.reload = wdata[W-1:0];
        end
        if (zero_evt)   st_d.ctrl.ps = 1'b1;
        else if (clr_d) st_d.ctrl.ps = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign reload = st_q.reload;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              freeze_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              irq,
    output logic [LVL_W-1:0]  irq_level
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             zero_evt;
    logic             wr_ctrl, wr_reload, run, frozen, load_en;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_reload = reg_wr && (reg_addr == A_RELOAD);
    assign frozen    = ctrl.frz && freeze_in;
    assign run       = tick_en && ctrl.te && !frozen;
    assign load_en   = wr_reload && !ctrl.te;

    pit_ctrl_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
        .wdata(reg_wdata), .zero_evt(zero_evt), .ctrl(ctrl), .reload(reload)
    );

    pit_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .load_en(load_en),
        .load_val(reg_wdata[CNT_W-1:0]), .reload(reload),
        .cnt(cnt), .zero_evt(zero_evt)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_W-1 -: LVL_W] = ctrl.lvl;
                reg_rdata[BIT_PS]            = ctrl.ps;
                reg_rdata[BIT_PIE]           = ctrl.pie;
                reg_rdata[BIT_FRZ]           = ctrl.frz;
                reg_rdata[BIT_TE]            = ctrl.te;
            end
            A_RELOAD: reg_rdata[CNT_W-1:0] = reload;
            A_COUNT:  reg_rdata[CNT_W-1:0] = cnt;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = ctrl.pie && ctrl.ps;
    assign irq_level = ctrl.lvl;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        freeze_in,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        irq,
    input logic [15:0] cnt,
    input logic [15:0] reload,
    input logic        ps,
    input logic        pie,
    input logic        frz,
    input logic        te,
    input logic        zero_evt
);
    logic clr_wr, rel_wr;
    assign clr_wr = reg_wr && (reg_addr == 2'd0) && reg_wdata[7];
    assign rel_wr = reg_wr && (reg_addr == 2'd1);

    p_set_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> ps);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && clr_wr) |=> ps);
    p_zero_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps && !clr_wr) |=> ps);
    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!te && !rel_wr) |=> $stable(cnt));
    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && freeze_in && !rel_wr) |=> $stable(cnt));
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && te && !(frz && freeze_in) && cnt == 16'd0) |=> (cnt == $past(reload)));
    p_direct_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!te && rel_wr) |=> (cnt == $past(reg_wdata)));
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pie && ps));
endmodule

bind pit_timer pit_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze_in(freeze_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
    .cnt(cnt), .reload(reload), .ps(ctrl.ps), .pie(ctrl.pie), .frz(ctrl.frz),
    .te(ctrl.te), .zero_evt(zero_evt)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, freeze_in = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [7:0]  irq_level;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural model state
    int m_cnt = 0, m_rel = 0, m_lvl = 0;
    bit m_ps = 0, m_pie = 0, m_frz = 0, m_te = 0;

    pit_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze_in(freeze_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_level(irq_level)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_lvl = 0;
            m_ps = 0; m_pie = 0; m_frz = 0; m_te = 0;
        end else begin
            bit run, evt, clr, old_te;
            int nxt;
            old_te = m_te;
            run = tick_en && m_te && !(m_frz && freeze_in);
            nxt = m_cnt;
            evt = 0;
            clr = 0;
            if (run) begin
                nxt = (m_cnt == 0) ? m_rel : m_cnt - 1;
                evt = (nxt == 0);
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_lvl = reg_wdata[15:8];
                m_pie = reg_wdata[2];
                m_frz = reg_wdata[1];
                m_te  = reg_wdata[0];
                clr   = reg_wdata[7];
            end
            if (evt) m_ps = 1;
            else if (clr) m_ps = 0;
            if (reg_wr && reg_addr == 2'd1) begin
                m_rel = reg_wdata;
                if (!old_te) nxt = reg_wdata;
            end
            m_cnt = nxt;
        end
    end

    function automatic logic [15:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return {m_lvl[7:0], m_ps, 4'b0000, m_pie, m_frz, m_te};
            2'd1: return m_rel[15:0];
            2'd2: return m_cnt[15:0];
            default: return 16'h0000;
        endcase
    endfunction

    // compare two time units after each falling edge, after inputs have settled
    always @(negedge clk) begin
        #2;
        if (!done) begin
            logic [15:0] er;
            logic        ei;
            er = exp_rdata(reg_addr);
            ei = m_pie && m_ps;
            checks++;
            if (reg_rdata !== er || irq !== ei || irq_level !== m_lvl[7:0]) begin
                errors++;
                $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b level=%h exp=%h",
                         cur_req, reg_addr, reg_rdata, er, irq, ei, irq_level, m_lvl[7:0]);
            end
        end
    end

    task automatic step(input bit t, input bit f, input bit w, input logic [1:0] a,
                        input logic [15:0] d);
        @(negedge clk);
        tick_en = t; freeze_in = f; reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle_ticks(input int n, input bit f);
        for (int i = 0; i < n; i++) step(1'b1, f, 1'b0, 2'(i % 3), 16'h0);
    endtask

    initial begin
        // R1: reset state, read every address
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 2'(i), 16'hFFFF);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 2'(i), 16'h0);

        // R10: reload write while disabled loads the counter
        cur_req = "R10";
        step(1'b0, 1'b0, 1'b1, 2'd1, 16'd5);
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'h0);

        // R2: field layout, reserved bits read zero, writes to count ignored
        cur_req = "R2";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'hFF7A);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        step(1'b0, 1'b0, 1'b1, 2'd2, 16'h1234);
        step(1'b0, 1'b0, 1'b1, 2'd3, 16'h4321);
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'h0);
        step(1'b0, 1'b0, 1'b0, 2'd3, 16'h0);

        // R3 R4 R7: run with interrupt enabled, several periods
        cur_req = "R3_R4_R7";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h3C05);
        idle_ticks(20, 1'b0);

        // R5: writing zero to status keeps it, writing one clears
        cur_req = "R5";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h3C05);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h3C85);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);

        // R7: status set with interrupt disabled keeps irq low
        cur_req = "R7";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h3C01);
        idle_ticks(8, 1'b0);
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h3C05);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);

        // R10: reload write while running leaves the count alone
        cur_req = "R10";
        step(1'b1, 1'b0, 1'b1, 2'd1, 16'd0);
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'h0);

        // R6: reload zero makes every tick an event; clear collides with set
        cur_req = "R6";
        idle_ticks(6, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 2'd0, 16'h5585);
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h5585);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);

        // R9: freeze control clear, freeze input has no effect
        cur_req = "R9";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0005);
        step(1'b0, 1'b0, 1'b1, 2'd1, 16'd9);
        idle_ticks(6, 1'b1);
        // freeze control set: counter stops while freeze input high
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0007);
        idle_ticks(6, 1'b1);
        idle_ticks(6, 1'b0);

        // R8: disabled timer holds its count
        cur_req = "R8";
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0006);
        idle_ticks(8, 1'b0);
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0007);

        // R3: mixed random traffic, sparse ticks and writes
        cur_req = "R3_mixed";
        step(1'b0, 1'b0, 1'b1, 2'd1, 16'd3);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[7:0] < 8'd12)
                step(r[8], r[9], 1'b1, 2'd0, {r[23:16], r[10], 4'b0, r[11], r[12], (r[13] | r[14])});
            else if (r[7:0] < 8'd16)
                step(r[8], r[9], 1'b1, 2'd1, {12'h0, r[19:16]});
            else
                step(r[8], r[9] & r[15], 1'b0, r[21:20], 16'h0);
        end

        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        @(negedge clk); #4;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule